// File: doc/BRIEF.md
# Pulse Width Measurement Timer

A 16-bit down-counter peripheral behind a byte-wide register port, built to time how long an external signal stays at one level, for example the on-periods of a detected ring signal. Software programs a 16-bit reload value, selects the level to measure and clears the stop bit. The counter then steps down by one on every count-source tick (`tick_en`) while the synchronized input pin is at the measured level, and freezes while the pin is at the other level.

Each time the counter is at zero and takes a tick, it reloads and raises a one-clock timer request. A reload value of N therefore divides the tick rate by N+1. Software counts these requests to measure long pulses. A separate one-clock pin request marks the end of the measured level: the falling edge when the high level is measured, the rising edge when the low level is measured. The reload value is written low byte first. The write of the high byte commits both bytes at once. Counter reads are coherent across the two bytes.

Top module: `pulse_width_timer`

## Requirements
- R1: After reset, the mode register (address 0), the enable register (address 3), the reload value and the counter are all 0. `tmr_irq` and `pin_irq` are low.
- R2: A write to address 1 only holds the low byte. Writing the high byte to address 2 loads the reload value and the counter together with {high, held low}. A low-byte write alone leaves the counter unchanged.
- R3: When mode bit 7 (stop) is 1, the counter holds its value whatever the pin and `tick_en` do.
- R4: With mode bits 5:4 = 2'b11 and bit 7 = 0, the counter decrements by one per clock with `tick_en` high, but only while the pin, after a two-flop synchronizer, is at the measured level. Bit 6 = 0 measures high and bit 6 = 1 measures low. Any other value of bits 5:4 stops counting.
- R5: A counting tick taken at zero reloads the counter from the reload value. When enable bit 0 (address 3) is 1, that tick pulses `tmr_irq` for one clock on the following clock. The period is reload+1 ticks.
- R6: With enable bit 0 clear, no `tmr_irq` pulse appears, but the reload at underflow still happens.
- R7: When enable bit 1 is set, `pin_irq` pulses for one clock on the synchronized pin's falling edge if bit 6 = 0, or on its rising edge if bit 6 = 1. The opposite edge and a cleared enable bit produce no pulse. This request does not depend on bits 5:4 or 7.
- R8: The read data is registered and is valid on the clock after `rd_en`. Address 0 returns the mode byte and address 3 the enable byte. Address 1 returns the live low byte of the counter and captures its high byte. Address 2 returns the captured high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-source enable, one tick per high clock |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address 0..3 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 1 | Asynchronous pulse input |
| tmr_irq | output | 1 | Underflow request, one clock |
| pin_irq | output | 1 | Selected-edge request, one clock |

## Verification
The assertions check on every cycle that:
- the counter steps down by exactly one on a counting tick and holds while stopped;
- it reloads from the reload value at zero;
- the reload value cannot change on a low-byte write alone;
- each request appears only when its enable was set.

Only the bench scenarios can show the end-to-end behaviour:
- the synchronizer delay and the level gating under both polarities;
- the exact underflow period and pulse count;
- the edge chosen for the pin request;
- that a high-byte read returns the value captured by the earlier low-byte read, not the live one.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  localparam logic [1:0] MODE_PWM = 2'b11;

  typedef enum logic [1:0] {
    A_MODE = 2'd0,
    A_LO   = 2'd1,
    A_HI   = 2'd2,
    A_IEN  = 2'd3
  } pwt_addr_e;

  // polarity 0 measures high, 1 measures low
  function automatic logic level_match(input logic pin, input logic pol);
    return pin ^ pol;
  endfunction

  // polarity 0 -> falling edge, 1 -> rising edge
  function automatic logic edge_hit(input logic rise, input logic fall, input logic pol);
    return pol ? rise : fall;
  endfunction
endpackage

// File: rtl/pwt_sync.sv
module pwt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], pin};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
  assign fall  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/pwt_regs.sv
module pwt_regs #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   mode_q,
  output logic [DW-1:0]   ien_q,
  output logic            load_lo,
  output logic            load_hi,
  output logic [2*DW-1:0] load_val,
  output logic [2*DW-1:0] reload_q
);
  import pwt_pkg::*;
  logic [DW-1:0] lo_hold;

  assign load_lo  = wr_en && (addr == A_LO);
  assign load_hi  = wr_en && (addr == A_HI);
  assign load_val = {wdata, lo_hold};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      ien_q    <= '0;
      lo_hold  <= '0;
      reload_q <= '0;
    end else if (wr_en) begin
      unique case (addr)
        A_MODE: mode_q   <= wdata;
        A_LO:   lo_hold  <= wdata;
        A_HI:   reload_q <= load_val;
        A_IEN:  ien_q    <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwt_counter.sv
module pwt_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          count_ok,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] cnt_q,
  output logic          underflow
);
  function automatic logic [CW-1:0] step(input logic [CW-1:0] c, input logic [CW-1:0] r);
    return (c == '0) ? r : c - 1'b1;
  endfunction

  assign underflow = count_ok && (cnt_q == '0) && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load)     cnt_q <= load_val;
    else if (count_ok) cnt_q <= step(cnt_q, reload);
  end
endmodule

// File: rtl/pulse_width_timer.sv
module pulse_width_timer #(
  parameter int DW        = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          pin_in,
  output logic          tmr_irq,
  output logic          pin_irq
);
  import pwt_pkg::*;
  localparam int CW = 2 * DW;

  logic [DW-1:0] mode_q, ien_q, hi_hold;
  logic [CW-1:0] load_val, reload_q, cnt_q;
  logic          load_lo, load_hi, underflow;
  logic          pin_lvl, pin_rise, pin_fall;
  logic          stop_bit, pol_bit, meas_mode, count_ok, edge_evt;
  logic          tmr_ie, pin_ie;

  pwt_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pin_in),
    .level(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  pwt_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .mode_q(mode_q), .ien_q(ien_q), .load_lo(load_lo), .load_hi(load_hi),
    .load_val(load_val), .reload_q(reload_q)
  );

  assign stop_bit  = mode_q[7];
  assign pol_bit   = mode_q[6];
  assign meas_mode = (mode_q[5:4] == MODE_PWM);
  assign tmr_ie    = ien_q[0];
  assign pin_ie    = ien_q[1];
  assign count_ok  = tick_en && meas_mode && !stop_bit && level_match(pin_lvl, pol_bit);
  assign edge_evt  = edge_hit(pin_rise, pin_fall, pol_bit);

  pwt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .count_ok(count_ok), .load(load_hi),
    .load_val(load_val), .reload(reload_q), .cnt_q(cnt_q), .underflow(underflow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_irq <= 1'b0;
      pin_irq <= 1'b0;
    end else begin
      tmr_irq <= underflow && tmr_ie;
      pin_irq <= edge_evt && pin_ie;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata   <= '0;
      hi_hold <= '0;
    end else if (rd_en) begin
      unique case (addr)
        A_MODE: rdata <= mode_q;
        A_LO: begin
          rdata   <= cnt_q[DW-1:0];
          hi_hold <= cnt_q[CW-1:DW];
        end
        A_HI:   rdata <= hi_hold;
        A_IEN:  rdata <= ien_q;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwt_checker.sv
module pwt_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          count_ok,
  input logic          stop_bit,
  input logic          load_lo,
  input logic          load_hi,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] reload_q,
  input logic          tmr_ie,
  input logic          pin_ie,
  input logic          tmr_irq,
  input logic          pin_irq
);
  // R2: low byte alone never disturbs the reload value or counter
  a_r2_low_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (load_lo && !load_hi && !count_ok) |=> ($stable(reload_q) && $stable(cnt_q)));

  // R3: stop freezes the counter
  a_r3_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_bit && !load_hi) |=> $stable(cnt_q));

  // R4: one step per counting tick
  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (count_ok && !load_hi && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5: reload at zero
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (count_ok && !load_hi && cnt_q == '0) |=> (cnt_q == $past(reload_q)));

  // R5/R6: timer request only when enabled
  a_r6_tmr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_irq) |-> $past(tmr_ie));

  // R7: pin request only when enabled
  a_r7_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_irq) |-> $past(pin_ie));

  // R7: pin request lasts one clock
  a_r7_pin_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    pin_irq |=> !pin_irq);
endmodule

bind pulse_width_timer pwt_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .count_ok(count_ok), .stop_bit(stop_bit),
  .load_lo(load_lo), .load_hi(load_hi), .cnt_q(cnt_q), .reload_q(reload_q),
  .tmr_ie(tmr_ie), .pin_ie(pin_ie), .tmr_irq(tmr_irq), .pin_irq(pin_irq)
);

// File: tb/pulse_width_timer_bench.sv
module pulse_width_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0, pin_in = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tmr_irq, pin_irq;
  int         n_chk = 0, n_fail = 0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  pulse_width_timer u_pulse_width_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
    .tmr_irq(tmr_irq), .pin_irq(pin_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input int exp);
    logic [7:0] d;
    rd(a, d);
    check(req, int'(d), exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] v);
    wr(2'd1, v[7:0]);
    wr(2'd2, v[15:8]);
  endtask

  task automatic t_reset;
    check("R1 tmr_irq", int'(tmr_irq), 0);
    check("R1 pin_irq", int'(pin_irq), 0);
    rd_chk("R1 mode", 2'd0, 0);
    rd_chk("R1 ien", 2'd3, 0);
    rd_chk("R1 cnt lo", 2'd1, 0);
    rd_chk("R1 cnt hi", 2'd2, 0);
  endtask

  task automatic t_atomic_load;
    wr(2'd1, 8'h34);
    rd_chk("R2 low only", 2'd1, 8'h00);
    wr(2'd2, 8'h12);
    rd_chk("R2 committed lo", 2'd1, 8'h34);
    rd_chk("R2 committed hi", 2'd2, 8'h12);
  endtask

  task automatic t_gating;
    wr(2'd0, 8'h30);
    rd_chk("R8 mode read", 2'd0, 8'h30);
    set_pin(1'b0);
    ticks(10);
    rd_chk("R4 idle level", 2'd1, 8'h34);
    set_pin(1'b1);
    ticks(5);
    rd_chk("R4 high count lo", 2'd1, 8'h2F);
    rd_chk("R4 high count hi", 2'd2, 8'h12);
    wr(2'd0, 8'hB0);
    ticks(6);
    rd_chk("R3 stopped", 2'd1, 8'h2F);
    wr(2'd0, 8'h20);
    ticks(6);
    rd_chk("R4 other mode", 2'd1, 8'h2F);
    wr(2'd0, 8'h70);
    ticks(4);
    rd_chk("R4 low pol idle", 2'd1, 8'h2F);
    set_pin(1'b0);
    ticks(4);
    rd_chk("R4 low pol count", 2'd1, 8'h2B);
  endtask

  task automatic t_underflow(input logic ie, input int exp_pulses, input string req);
    int pulses = 0, run = 0, maxrun = 0;
    wr(2'd3, {7'd0, ie});
    wr(2'd0, 8'h30);
    set_pin(1'b1);
    load(16'h0003);
    @(negedge clk); tick_en = 1'b1;
    for (int i = 0; i < 22; i++) begin
      if (i == 20) tick_en = 1'b0;
      @(negedge clk);
      if (tmr_irq) begin pulses++; run++; end else run = 0;
      if (run > maxrun) maxrun = run;
    end
    tick_en = 1'b0;
    check({req, " pulses"}, pulses, exp_pulses);
    check({req, " width"}, maxrun, exp_pulses > 0 ? 1 : 0);
    rd_chk({req, " reloaded"}, 2'd1, 8'h03);
  endtask

  task automatic count_pin(input logic v, input int exp, input string req);
    int p = 0;
    @(negedge clk); pin_in = v;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (pin_irq) p++;
    end
    check(req, p, exp);
  endtask

  task automatic t_pin_irq;
    wr(2'd0, 8'h30);
    wr(2'd3, 8'h02);
    rd_chk("R8 ien read", 2'd3, 8'h02);
    count_pin(1'b0, 1, "R7 fall pol0");
    count_pin(1'b1, 0, "R7 rise pol0 ignored");
    wr(2'd0, 8'h70);
    count_pin(1'b0, 0, "R7 fall pol1 ignored");
    count_pin(1'b1, 1, "R7 rise pol1");
    wr(2'd3, 8'h00);
    count_pin(1'b0, 0, "R7 disabled fall");
    count_pin(1'b1, 0, "R7 disabled rise");
  endtask

  task automatic t_coherent;
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h30);
    set_pin(1'b1);
    load(16'h0100);
    rd_chk("R8 lo capture", 2'd1, 8'h00);
    ticks(1);
    rd_chk("R8 hi captured", 2'd2, 8'h01);
    rd_chk("R8 lo live", 2'd1, 8'hFF);
    rd_chk("R8 hi new", 2'd2, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_atomic_load();
    t_gating();
    t_underflow(1'b1, 5, "R5");
    t_underflow(1'b0, 0, "R6");
    t_pin_irq();
    t_coherent();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule